// File: doc/BRIEF.md
# Fractional PLL Frequency Calculator

This block works out three clock frequencies, in Hz, from a snapshot of three control words. The three frequencies are the core clock, the high-speed bus clock and the peripheral clock. A one-cycle request captures the mode word, the PLL control word and the divider word. The block first picks a PLL reference frequency. It then either passes that reference straight through (bypass) or evaluates a fractional-N PLL equation with a restoring shift-subtract divider that takes many cycles. After that it applies two post-dividers in cascade, each using the same divider.

The equation works at reduced precision. The reference is scaled down by 1024 before the multiply, the quotient is scaled back up by 1024 afterwards, and all arithmetic wraps modulo 2^32. When all three results are ready they are published together with a one-cycle `done_o` pulse, and they hold until the next calculation completes. A request that arrives during a calculation is remembered and served as soon as the current one finishes. Any number of such requests collapse into one.

Top module: `pll_freq_calc`

## Requirements
- R1: After reset, `busy_o` and `done_o` are low and all three frequency outputs are zero.
- R2: The reference frequency is 33,554,432 Hz (32768·1024) when mode bits [2:1] equal 2, and 26,000,000 Hz for any other value of those bits.
- R3: When mode bit 7 (force-reference) is set, or mode bit 0 (PLL enable) is clear, the core clock equals the reference frequency. All other mode bits have no effect.
- R4: Otherwise the core clock is ((2·(ref>>10)·(I·D + N)) mod 2^32 / (D·P)) · 1024 mod 2^32, with truncating division. The terms come from PLL control fields as follows: P = bits[29:26]+1 and D = bits[25:16]+1. I = bits[13:10], raised to 5 when below 5. N = bits[9:0] read as a signed two's-complement value.
- R5: The high-speed clock is the core clock divided by (1 + divider word bits [13:11]), truncated.
- R6: The peripheral clock is the high-speed clock divided by (1 + divider word bits [7:6]), truncated.
- R7: `busy_o` rises on the edge that samples a request. For the default width W=32, `done_o` is a single-cycle pulse raised 3·W+6 edges later in PLL mode and 2·W+5 edges later in bypass. `busy_o` falls on that same edge.
- R8: The three outputs change only on the edge that raises `done_o`, and all three change together.
- R9: A request seen while busy, including on the completing edge, starts one new calculation on the edge after `done_o` rises. Its control words are sampled on that edge. Several such requests give only one extra calculation.
- R10: Control words are sampled only on the edge that starts a calculation. Changes to them during a calculation do not affect its results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Calculation request |
| mode_i | input | 32 | Mode word (enable, reference select, force-reference) |
| pll_ctl_i | input | 32 | PLL control word (pre-divider, denominator, integer, numerator) |
| div_ctl_i | input | 32 | Post-divider word |
| busy_o | output | 1 | Calculation in progress |
| done_o | output | 1 | One-cycle pulse when results are published |
| main_hz_o | output | 32 | Core clock frequency in Hz |
| fast_hz_o | output | 32 | High-speed clock frequency in Hz |
| periph_hz_o | output | 32 | Peripheral clock frequency in Hz |

## Verification
The hardest situation to reach from the ports is a queued request whose control words differ from those of the calculation in flight. The bench has to show that the first result ignores the new words and the second one uses them. To get there, the stimulus starts a calculation and changes all three control words mid-run. It then pulses the request several more times while busy, and afterwards idles long enough to show that only one extra calculation ran. The negative-numerator wrap of the PLL term is also reached on purpose, by choosing a numerator of -512 against the smallest denominator.

// File: rtl/pllc_pkg.sv
package pllc_pkg;

  // Bit positions in the mode word
  localparam int unsigned MODE_EN_BIT    = 0;
  localparam int unsigned MODE_SEL_LO    = 1;
  localparam int unsigned MODE_FORCE_BIT = 7;
  localparam logic [1:0]  SEL_ALT_REF    = 2'd2;

  // Post-divider fields
  localparam int unsigned HSP_LO = 11;
  localparam int unsigned IPG_LO = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PLL_GO,
    ST_PLL_WAIT,
    ST_HSP_GO,
    ST_HSP_WAIT,
    ST_IPG_GO,
    ST_IPG_WAIT
  } calc_st_e;

  typedef struct packed {
    logic [3:0] pd;
    logic [9:0] mfd;
    logic [3:0] mfi;
    logic [9:0] mfn;
  } pll_fields_t;

  function automatic pll_fields_t unpack_pll(input logic [31:0] c);
    pll_fields_t f;
    f.pd  = c[29:26];
    f.mfd = c[25:16];
    f.mfi = c[13:10];
    f.mfn = c[9:0];
    return f;
  endfunction

  // Dividend of the PLL equation, modulo 2^32
  function automatic logic [31:0] pll_dividend(input logic [31:0] ref_hz,
                                               input pll_fields_t f);
    logic [31:0] r10;
    logic [31:0] ie;
    logic [31:0] de;
    logic [31:0] ne;
    logic [31:0] term;
    r10  = ref_hz >> 10;
    ie   = (f.mfi < 4'd5) ? 32'd5 : {28'd0, f.mfi};
    de   = {22'd0, f.mfd} + 32'd1;
    ne   = {{22{f.mfn[9]}}, f.mfn};
    term = ie * de + ne;
    return (r10 << 1) * term;
  endfunction

  function automatic logic [31:0] pll_divisor(input pll_fields_t f);
    logic [31:0] de;
    logic [31:0] pe;
    de = {22'd0, f.mfd} + 32'd1;
    pe = {28'd0, f.pd} + 32'd1;
    return de * pe;
  endfunction

endpackage

// File: rtl/pllc_operands.sv
module pllc_operands
  import pllc_pkg::*;
#(
  parameter int unsigned DW        = 32,
  parameter int unsigned REF_XTAL  = 26000000,
  parameter int unsigned REF_ALT   = 33554432
) (
  input  logic [31:0]   mode_w,
  input  logic [31:0]   ctl_w,
  output logic [DW-1:0] ref_hz,
  output logic          bypass,
  output logic [DW-1:0] dividend,
  output logic [DW-1:0] divisor
);
  pll_fields_t fld;
  logic [1:0]  sel;

  always_comb begin
    sel      = mode_w[MODE_SEL_LO +: 2];
    ref_hz   = (sel == SEL_ALT_REF) ? DW'(REF_ALT) : DW'(REF_XTAL);
    bypass   = mode_w[MODE_FORCE_BIT] | ~mode_w[MODE_EN_BIT];
    fld      = unpack_pll(ctl_w);
    dividend = DW'(pll_dividend(32'(ref_hz), fld));
    divisor  = DW'(pll_divisor(fld));
  end
endmodule

// File: rtl/pllc_divider.sv
module pllc_divider #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dvd,
  input  logic [W-1:0] den,
  output logic         busy,
  output logic         fin,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [CW-1:0] cnt;
  logic [W-1:0]  dvd_q;
  logic [W-1:0]  den_q;
  logic [W:0]    rem_sh;
  logic          take;
  logic [W-1:0]  rem_nx;

  always_comb begin
    rem_sh = {rem, quo[W-1]};
    take   = rem_sh >= {1'b0, den_q};
    rem_nx = take ? W'(rem_sh - {1'b0, den_q}) : rem_sh[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      busy  <= 1'b0;
      fin   <= 1'b0;
      quo   <= '0;
      rem   <= '0;
      dvd_q <= '0;
      den_q <= '0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        rem   <= '0;
        quo   <= dvd;
        dvd_q <= dvd;
        den_q <= den;
        cnt   <= CW'(W);
        busy  <= 1'b1;
      end else if (busy) begin
        rem <= rem_nx;
        quo <= {quo[W-2:0], take};
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end
  end

  // R4
  div_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> ((64'(quo) * 64'(den_q) + 64'(rem)) == 64'(dvd_q)) && (rem < den_q));

  // R7
  div_fin_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin);
endmodule

// File: rtl/pll_freq_calc.sv
module pll_freq_calc
  import pllc_pkg::*;
#(
  parameter int unsigned DW       = 32,
  parameter int unsigned REF_XTAL = 26000000,
  parameter int unsigned REF_ALT  = 33554432,
  parameter int unsigned HSP_W    = 3,
  parameter int unsigned IPG_W    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [31:0]   mode_i,
  input  logic [31:0]   pll_ctl_i,
  input  logic [31:0]   div_ctl_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] main_hz_o,
  output logic [DW-1:0] fast_hz_o,
  output logic [DW-1:0] periph_hz_o
);
  localparam int unsigned SCALE_SH = 10;

  calc_st_e      state;
  logic          pend;
  logic [31:0]   cap_mode;
  logic [31:0]   cap_ctl;
  logic [31:0]   cap_div;
  logic [DW-1:0] work_main;
  logic [DW-1:0] work_fast;

  logic [DW-1:0] op_ref;
  logic          op_bypass;
  logic [DW-1:0] op_dvd;
  logic [DW-1:0] op_den;

  logic          div_go;
  logic [DW-1:0] div_dvd;
  logic [DW-1:0] div_den;
  logic          div_busy;
  logic          div_fin;
  logic [DW-1:0] div_quo;
  logic [DW-1:0] div_rem;

  logic [HSP_W-1:0] hsp_f;
  logic [IPG_W-1:0] ipg_f;

  pllc_operands #(
    .DW(DW), .REF_XTAL(REF_XTAL), .REF_ALT(REF_ALT)
  ) u_ops (
    .mode_w(cap_mode), .ctl_w(cap_ctl), .ref_hz(op_ref),
    .bypass(op_bypass), .dividend(op_dvd), .divisor(op_den)
  );

  pllc_divider #(.W(DW)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go), .dvd(div_dvd), .den(div_den),
    .busy(div_busy), .fin(div_fin), .quo(div_quo), .rem(div_rem)
  );

  always_comb begin
    hsp_f   = cap_div[HSP_LO +: HSP_W];
    ipg_f   = cap_div[IPG_LO +: IPG_W];
    div_go  = 1'b0;
    div_dvd = op_dvd;
    div_den = op_den;
    case (state)
      ST_PLL_GO: div_go = ~op_bypass;
      ST_HSP_GO: begin
        div_go  = 1'b1;
        div_dvd = work_main;
        div_den = DW'(hsp_f) + DW'(1);
      end
      ST_IPG_GO: begin
        div_go  = 1'b1;
        div_dvd = work_fast;
        div_den = DW'(ipg_f) + DW'(1);
      end
      default: ;
    endcase
  end

  assign busy_o = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      pend        <= 1'b0;
      cap_mode    <= '0;
      cap_ctl     <= '0;
      cap_div     <= '0;
      work_main   <= '0;
      work_fast   <= '0;
      done_o      <= 1'b0;
      main_hz_o   <= '0;
      fast_hz_o   <= '0;
      periph_hz_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i && state != ST_IDLE) pend <= 1'b1;
      case (state)
        ST_IDLE: if (start_i || pend) begin
          cap_mode <= mode_i;
          cap_ctl  <= pll_ctl_i;
          cap_div  <= div_ctl_i;
          pend     <= 1'b0;
          state    <= ST_PLL_GO;
        end
        ST_PLL_GO: if (op_bypass) begin
          work_main <= op_ref;
          state     <= ST_HSP_GO;
        end else begin
          state <= ST_PLL_WAIT;
        end
        ST_PLL_WAIT: if (div_fin) begin
          work_main <= div_quo << SCALE_SH;
          state     <= ST_HSP_GO;
        end
        ST_HSP_GO: state <= ST_HSP_WAIT;
        ST_HSP_WAIT: if (div_fin) begin
          work_fast <= div_quo;
          state     <= ST_IPG_GO;
        end
        ST_IPG_GO: state <= ST_IPG_WAIT;
        ST_IPG_WAIT: if (div_fin) begin
          main_hz_o   <= work_main;
          fast_hz_o   <= work_fast;
          periph_hz_o <= div_quo;
          done_o      <= 1'b1;
          state       <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  // R3
  bypass_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && op_bypass) |-> (main_hz_o == op_ref));

  // R5
  fast_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (fast_hz_o <= main_hz_o) && (periph_hz_o <= fast_hz_o));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(main_hz_o) && $stable(fast_hz_o) && $stable(periph_hz_o));

  // R9
  pend_serve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && pend) |=> busy_o);
endmodule

// File: tb/pll_freq_calc_tb.sv
module pll_freq_calc_tb_top;
  localparam int W       = 32;
  localparam int LAT_PLL = 3 * W + 6;
  localparam int LAT_BYP = 2 * W + 5;
  localparam longint M32 = 64'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] mode_i = '0;
  logic [31:0] pll_ctl_i = '0;
  logic [31:0] div_ctl_i = '0;
  logic        busy_o, done_o;
  logic [31:0] main_hz_o, fast_hz_o, periph_hz_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pll_freq_calc dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .pll_ctl_i(pll_ctl_i), .div_ctl_i(div_ctl_i), .busy_o(busy_o),
    .done_o(done_o), .main_hz_o(main_hz_o), .fast_hz_o(fast_hz_o),
    .periph_hz_o(periph_hz_o)
  );

  // Reference arithmetic, written from the requirements
  function automatic longint f_ref(logic [31:0] m);
    return (m[2:1] == 2'd2) ? 64'd33554432 : 64'd26000000;
  endfunction
  function automatic bit f_byp(logic [31:0] m);
    return m[7] || !m[0];
  endfunction
  function automatic longint f_main(logic [31:0] m, logic [31:0] c);
    longint r, ii, dd, pp, nn, num, q;
    r = f_ref(m);
    if (f_byp(m)) return r;
    ii = c[13:10]; if (ii < 5) ii = 5;
    dd = longint'(c[25:16]) + 1;
    pp = longint'(c[29:26]) + 1;
    nn = c[9:0]; if (c[9]) nn = nn - 1024;
    num = (2 * (r / 1024) * (ii * dd + nn)) & M32;
    q = num / (dd * pp);
    return (q * 1024) & M32;
  endfunction
  function automatic longint f_fast(longint mn, logic [31:0] d);
    return mn / (longint'(d[13:11]) + 1);
  endfunction
  function automatic longint f_per(longint fs, logic [31:0] d);
    return fs / (longint'(d[7:6]) + 1);
  endfunction

  // Cycle-by-cycle model
  bit     m_busy, m_pend, m_done;
  int     m_cnt;
  longint m_main, m_fast, m_per, n_main, n_fast, n_per;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst_n) begin
      m_busy = 0; m_pend = 0; m_done = 0; m_cnt = 0;
      m_main = 0; m_fast = 0; m_per = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (start_i) m_pend = 1;
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0; m_done = 1;
          m_main = n_main; m_fast = n_fast; m_per = n_per;
        end
      end else if (start_i || m_pend) begin
        m_pend = 0;
        n_main = f_main(mode_i, pll_ctl_i);
        n_fast = f_fast(n_main, div_ctl_i);
        n_per  = f_per(n_fast, div_ctl_i);
        m_cnt  = f_byp(mode_i) ? LAT_BYP : LAT_PLL;
        m_busy = 1;
      end
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(m_done ? "R7 done" : "R7 done idle", done_o, m_done);
      chk("R7 busy", busy_o, m_busy);
      chk(m_done ? "R4 main" : "R8 main hold", main_hz_o, m_main);
      chk(m_done ? "R5 fast" : "R8 fast hold", fast_hz_o, m_fast);
      chk(m_done ? "R6 periph" : "R8 periph hold", periph_hz_o, m_per);
    end
  end

  task automatic wait_done();
    do @(negedge clk); while (!done_o);
  endtask

  task automatic run(string tag, logic [31:0] m, logic [31:0] c, logic [31:0] d);
    longint em, ef;
    @(negedge clk);
    mode_i = m; pll_ctl_i = c; div_ctl_i = d; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done();
    em = f_main(m, c);
    ef = f_fast(em, d);
    chk({tag, " main"}, main_hz_o, em);
    chk({tag, " fast"}, fast_hz_o, ef);
    chk({tag, " periph"}, periph_hz_o, f_per(ef, d));
  endtask

  function automatic logic [31:0] pctl(int pd, int mfd, int mfi, int mfn);
    return (32'(pd) << 26) | (32'(mfd) << 16) | (32'(mfi) << 10) | (32'(mfn) & 32'h3FF);
  endfunction
  function automatic logic [31:0] dctl(int h, int i);
    return (32'(h) << 11) | (32'(i) << 6);
  endfunction

  initial begin : watchdog
    wait (cycles > 30000);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<30000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] ca, cb;
    longint ea, eb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 main", main_hz_o, 0);
    chk("R1 fast", fast_hz_o, 0);
    chk("R1 periph", periph_hz_o, 0);

    // R2 alternate reference, forced bypass
    run("R2 alt", 32'h0000_0085, pctl(1, 0, 6, 0), dctl(0, 0));
    chk("R2 alt ref", main_hz_o, 33554432);
    // R2/R3 crystal reference, PLL disabled
    run("R3 off", 32'h0000_0002, pctl(1, 0, 6, 0), dctl(3, 1));
    chk("R2 xtal ref", main_hz_o, 26000000);
    // R4 typical settings
    run("R4 typ", 32'h0000_0001, pctl(1, 0, 6, 0), dctl(1, 1));
    chk("R4 typ value", main_hz_o, 155996160);
    // R4 clamped integer part
    run("R4 clamp", 32'h0000_0005, pctl(0, 4, 2, 1), dctl(0, 2));
    // R4 negative numerator
    run("R4 neg", 32'h0000_0001, pctl(2, 9, 9, -3), dctl(2, 0));
    // R4 wrap of the negative term
    run("R4 wrap", 32'h0000_0001, pctl(0, 0, 5, -512), dctl(0, 0));
    // R5/R6 largest fields and post-dividers
    run("R6 max", 32'h0000_0003, pctl(15, 1023, 15, 511), dctl(7, 3));
    // R3 unrelated mode bits set, PLL still active
    run("R3 other bits", 32'hFFFF_FF7F, pctl(3, 100, 8, 200), dctl(5, 3));

    // R10 control words changed mid-run are ignored
    ca = pctl(1, 2, 10, 7);
    cb = pctl(4, 50, 12, -100);
    @(negedge clk);
    mode_i = 32'h1; pll_ctl_i = ca; div_ctl_i = dctl(1, 0); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    pll_ctl_i = cb; div_ctl_i = dctl(6, 3); mode_i = 32'h5;
    wait_done();
    ea = f_main(32'h1, ca);
    chk("R10 main", main_hz_o, ea);
    chk("R10 fast", fast_hz_o, f_fast(ea, dctl(1, 0)));
    chk("R10 busy", busy_o, 0);

    // R9 queued request while busy, served once with words sampled later
    @(negedge clk);
    mode_i = 32'h1; pll_ctl_i = ca; div_ctl_i = dctl(0, 1); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (10) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    mode_i = 32'h3; pll_ctl_i = cb; div_ctl_i = dctl(2, 2);
    repeat (20) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done();
    chk("R9 first", main_hz_o, f_main(32'h1, ca));
    @(negedge clk);
    chk("R9 restart busy", busy_o, 1);
    wait_done();
    eb = f_main(32'h3, cb);
    chk("R9 second main", main_hz_o, eb);
    chk("R9 second periph", periph_hz_o, f_per(f_fast(eb, dctl(2, 2)), dctl(2, 2)));
    repeat (LAT_PLL + 10) @(negedge clk);
    chk("R9 single extra", busy_o, 0);
    chk("R9 value kept", main_hz_o, eb);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule